// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is the target side of a message mailbox between a host processor and a coprocessor, seen by the host as a 256-byte register window. The host first loads up to four payload words into a write buffer. It then writes a command word, and that write acts as the doorbell. While the command is accepted the block holds the command word and raises a busy flag. It also sends a one-cycle doorbell pulse to the coprocessor.

The coprocessor reads the held command word and the payload through a side port of its own. It leaves response bytes in a 16-byte read buffer and then pulses a done strobe that carries an error flag and an error code. The block latches the outcome into a status word that the host can poll. If the command asked for it, the block also pulses an interrupt back to the host. The status word keeps the outcome until the next command is accepted.

Top module: `ipc_mbox`

## Requirements
- R1: After reset, the status word reads zero, the read buffer reads zero, and the doorbell and host interrupt outputs are low.
- R2: When the block is idle, a host write to offset 0x00 is accepted. From the next cycle, status bit 0 (busy) is 1, status bits 7:4 hold command bits 15:12, status bits 15:8 hold the INITIATOR_ID parameter, and the coprocessor command output equals the written word.
- R3: The doorbell output is high for exactly one cycle, in the cycle after an accepted command write.
- R4: A host command write that arrives while busy is ignored: no doorbell is raised and the held command word does not change.
- R5: A done strobe while busy clears busy in the next cycle. It latches the error flag into status bit 1 and the error code into status bits 23:16. Both stay set until the next accepted command clears them.
- R6: The host interrupt is a one-cycle pulse in the cycle after completion. It is raised only if bit 8 of the held command was set.
- R7: Host word writes at offsets 0x80 + 4k (k = 0 to 3) fill write-buffer word k, which the coprocessor reads by index. Host reads of that range return zero.
- R8: A coprocessor byte write to read-buffer byte j is seen by the host at offset 0x90 + 4*(j/4), in byte lane j mod 4 (little-endian).
- R9: Host writes to the status word (0x04) or to the read buffer are dropped. Host reads of the command offset or of unmapped offsets return zero.
- R10: A done strobe while idle changes neither the status word nor the host interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 8 | Host byte offset in the window (word aligned) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| host_irq | output | 1 | Completion interrupt pulse to the host |
| cp_doorbell | output | 1 | Doorbell pulse to the coprocessor |
| cp_cmd | output | 32 | Held command word |
| cp_wb_idx | input | 2 | Write-buffer word index read by the coprocessor |
| cp_wb_data | output | 32 | Selected write-buffer word |
| cp_rb_we | input | 1 | Coprocessor read-buffer byte write strobe |
| cp_rb_idx | input | 4 | Read-buffer byte index |
| cp_rb_data | input | 8 | Read-buffer byte data |
| cp_done | input | 1 | Completion strobe |
| cp_err | input | 1 | Error flag qualified by cp_done |
| cp_err_code | input | 8 | Error code qualified by cp_done |

## Verification
A wrong busy state shows at the ports one cycle after a command write or a done strobe. It appears as a missing or repeated doorbell, a command word overwritten by a second write, or a busy bit in the status word that stays up or drops too early. A bad error latch shows on the very next status read after completion, and again after a later command that should have cleared it. Decode faults appear at once on combinational host reads or on the coprocessor's view of the write buffer. Writes that should have been dropped are caught by reading the target location back.

// File: rtl/ipc_mbox.sv
module ipc_mbox #(
  parameter int WB_WORDS = 4,
  parameter int RB_BYTES = 16,
  parameter logic [7:0] INITIATOR_ID = 8'h5A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [7:0]                  host_addr,
  input  logic                        host_wr,
  input  logic [31:0]                 host_wdata,
  output logic [31:0]                 host_rdata,
  output logic                        host_irq,
  output logic                        cp_doorbell,
  output logic [31:0]                 cp_cmd,
  input  logic [$clog2(WB_WORDS)-1:0] cp_wb_idx,
  output logic [31:0]                 cp_wb_data,
  input  logic                        cp_rb_we,
  input  logic [$clog2(RB_BYTES)-1:0] cp_rb_idx,
  input  logic [7:0]                  cp_rb_data,
  input  logic                        cp_done,
  input  logic                        cp_err,
  input  logic [7:0]                  cp_err_code
);
  localparam int WBI_W = $clog2(WB_WORDS);
  localparam int RB_WORDS = RB_BYTES / 4;
  localparam int RBW_W = $clog2(RB_WORDS);
  localparam logic [7:0] CMD_OFS = 8'h00;
  localparam logic [7:0] STS_OFS = 8'h04;
  localparam logic [7:0] WB_BASE = 8'h80;
  localparam logic [7:0] RB_BASE = 8'h90;
  localparam logic [8:0] WB_END = 9'(int'(WB_BASE) + 4 * WB_WORDS);
  localparam logic [8:0] RB_END = 9'(int'(RB_BASE) + RB_BYTES);

  logic        busy_q, err_q;
  logic [7:0]  code_q, init_q;
  logic [31:0] cmd_q;
  logic [31:0] wbuf [WB_WORDS];
  logic [7:0]  rbuf [RB_BYTES];
  logic [31:0] rb_word [RB_WORDS];

  wire [8:0] addr9   = {1'b0, host_addr};
  wire       hit_cmd = host_addr[7:2] == CMD_OFS[7:2];
  wire       hit_sts = host_addr[7:2] == STS_OFS[7:2];
  wire       hit_wb  = addr9 >= {1'b0, WB_BASE} && addr9 < WB_END;
  wire       hit_rb  = addr9 >= {1'b0, RB_BASE} && addr9 < RB_END;
  wire [7:0] wb_off  = host_addr - WB_BASE;
  wire [7:0] rb_off  = host_addr - RB_BASE;
  wire [WBI_W-1:0] wb_sel = WBI_W'(wb_off >> 2);
  wire [RBW_W-1:0] rb_sel = RBW_W'(rb_off >> 2);

  wire accept = host_wr && hit_cmd && !busy_q;
  wire finish = cp_done && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      err_q       <= 1'b0;
      code_q      <= 8'h00;
      init_q      <= 8'h00;
      cmd_q       <= 32'h0;
      cp_doorbell <= 1'b0;
      host_irq    <= 1'b0;
    end else begin
      cp_doorbell <= accept;
      host_irq    <= finish && cmd_q[8];
      if (accept) begin
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= 8'h00;
        init_q <= INITIATOR_ID;
        cmd_q  <= host_wdata;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= cp_err;
        code_q <= cp_err_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WB_WORDS; i++) wbuf[i] <= 32'h0;
    end else if (host_wr && hit_wb) begin
      wbuf[wb_sel] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RB_BYTES; i++) rbuf[i] <= 8'h00;
    end else if (cp_rb_we) begin
      rbuf[cp_rb_idx] <= cp_rb_data;
    end
  end

  for (genvar w = 0; w < RB_WORDS; w++) begin : g_rbw
    assign rb_word[w] = {rbuf[4*w+3], rbuf[4*w+2], rbuf[4*w+1], rbuf[4*w]};
  end

  wire [31:0] status = {8'h00, code_q, init_q, cmd_q[15:12], 2'b00, err_q, busy_q};

  always_comb begin
    host_rdata = 32'h0;
    if (hit_sts) host_rdata = status;
    else if (hit_rb) host_rdata = rb_word[rb_sel];
  end

  assign cp_cmd     = cmd_q;
  assign cp_wb_data = wbuf[cp_wb_idx];
endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        doorbell,
  input logic        host_irq,
  input logic [31:0] cmd,
  input logic        done
);
  assert_doorbell_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);

  assert_doorbell_with_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> busy);

  assert_cmd_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd));

  assert_done_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);

  assert_irq_on_completion_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (cmd[8] && !busy && $past(busy)));

  assert_idle_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && done) |=> !host_irq);
endmodule

bind ipc_mbox ipc_mbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .doorbell(cp_doorbell),
  .host_irq(host_irq), .cmd(cp_cmd), .done(cp_done)
);

// File: tb/test_ipc_mbox.sv
module test_ipc_mbox;
  localparam int PERIOD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata;
  logic        host_irq, cp_doorbell;
  logic [31:0] cp_cmd, cp_wb_data;
  logic [1:0]  cp_wb_idx = 2'd0;
  logic        cp_rb_we = 1'b0;
  logic [3:0]  cp_rb_idx = 4'd0;
  logic [7:0]  cp_rb_data = 8'h00;
  logic        cp_done = 1'b0, cp_err = 1'b0;
  logic [7:0]  cp_err_code = 8'h00;

  int checks = 0, fails = 0;
  bit ended = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ipc_mbox i_ipc_mbox (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .cp_doorbell(cp_doorbell), .cp_cmd(cp_cmd), .cp_wb_idx(cp_wb_idx),
    .cp_wb_data(cp_wb_data), .cp_rb_we(cp_rb_we), .cp_rb_idx(cp_rb_idx),
    .cp_rb_data(cp_rb_data), .cp_done(cp_done), .cp_err(cp_err),
    .cp_err_code(cp_err_code)
  );

  // op: 0 host write, 1 host read check, 2 coprocessor byte write, 3 coprocessor word check
  localparam logic [73:0] VEC [21] = '{
    {2'd0, 8'h80, 32'h11223344, 32'h0},        // R7
    {2'd0, 8'h84, 32'h55667788, 32'h0},        // R7
    {2'd0, 8'h8C, 32'hDEADBEEF, 32'h0},        // R7
    {2'd3, 8'h00, 32'h0, 32'h11223344},        // R7
    {2'd3, 8'h01, 32'h0, 32'h55667788},        // R7
    {2'd3, 8'h03, 32'h0, 32'hDEADBEEF},        // R7
    {2'd1, 8'h80, 32'h0, 32'h0},               // R7 write-only reads zero
    {2'd1, 8'h8C, 32'h0, 32'h0},               // R7
    {2'd2, 8'h00, 32'hA1, 32'h0},              // R8
    {2'd2, 8'h01, 32'hB2, 32'h0},              // R8
    {2'd2, 8'h02, 32'hC3, 32'h0},              // R8
    {2'd2, 8'h03, 32'hD4, 32'h0},              // R8
    {2'd2, 8'h0F, 32'h5E, 32'h0},              // R8
    {2'd1, 8'h90, 32'h0, 32'hD4C3B2A1},        // R8
    {2'd1, 8'h9C, 32'h0, 32'h5E000000},        // R8
    {2'd0, 8'h90, 32'hFFFFFFFF, 32'h0},        // R9 dropped
    {2'd1, 8'h90, 32'h0, 32'hD4C3B2A1},        // R9
    {2'd0, 8'h04, 32'hFFFFFFFF, 32'h0},        // R9 dropped
    {2'd1, 8'h04, 32'h0, 32'h0},               // R9
    {2'd1, 8'h40, 32'h0, 32'h0},               // R9 unmapped
    {2'd1, 8'h00, 32'h0, 32'h0}                // R9 command reads zero
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input string tag, input logic [7:0] a, input logic [31:0] exp);
    host_addr = a;
    #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic rbwrite(input logic [3:0] j, input logic [7:0] d);
    @(negedge clk);
    cp_rb_we = 1'b1; cp_rb_idx = j; cp_rb_data = d;
    @(negedge clk);
    cp_rb_we = 1'b0;
  endtask

  task automatic complete(input logic e, input logic [7:0] code);
    @(negedge clk);
    cp_done = 1'b1; cp_err = e; cp_err_code = code;
    @(negedge clk);
    cp_done = 1'b0; cp_err = 1'b0; cp_err_code = 8'h00;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    hread("R1 status", 8'h04, 32'h0);
    hread("R1 read buffer", 8'h9C, 32'h0);
    chk("R1 doorbell", {31'h0, cp_doorbell}, 32'h0);
    chk("R1 irq", {31'h0, host_irq}, 32'h0);

    for (int i = 0; i < 21; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        2'd0: hwrite(a, d);
        2'd1: hread("R7/R8/R9 host read", a, e);
        2'd2: rbwrite(a[3:0], d[7:0]);
        default: begin
          cp_wb_idx = a[1:0];
          #1;
          chk("R7 coprocessor view", cp_wb_data, e);
        end
      endcase
    end

    // R2/R3 accepted command with completion interrupt requested
    hwrite(8'h00, 32'h000451A5);
    chk("R3 doorbell high", {31'h0, cp_doorbell}, 32'h1);
    chk("R2 command held", cp_cmd, 32'h000451A5);
    hread("R2 status busy", 8'h04, 32'h00005A51);
    @(negedge clk);
    chk("R3 doorbell one cycle", {31'h0, cp_doorbell}, 32'h0);

    // R4 second command while busy
    hwrite(8'h00, 32'h000000F0);
    chk("R4 no doorbell", {31'h0, cp_doorbell}, 32'h0);
    chk("R4 command unchanged", cp_cmd, 32'h000451A5);

    // R5/R6 completion with error
    complete(1'b1, 8'h2C);
    chk("R6 irq pulse", {31'h0, host_irq}, 32'h1);
    hread("R5 status latched", 8'h04, 32'h002C5A52);
    @(negedge clk);
    chk("R6 irq one cycle", {31'h0, host_irq}, 32'h0);

    // R10 done while idle
    complete(1'b0, 8'h00);
    chk("R10 no irq", {31'h0, host_irq}, 32'h0);
    hread("R10 status unchanged", 8'h04, 32'h002C5A52);

    // R5 sticky error cleared by next command, R6 no irq without bit 8
    hwrite(8'h00, 32'h00003077);
    chk("R3 doorbell second command", {31'h0, cp_doorbell}, 32'h1);
    hread("R5 error cleared", 8'h04, 32'h00005A31);
    complete(1'b0, 8'h00);
    chk("R6 no irq without request", {31'h0, host_irq}, 32'h0);
    hread("R5 clean completion", 8'h04, 32'h00005A30);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule